// File: doc/BRIEF.md
# Stereo Serial Sample Receiver

This block is the receiving end of a two-channel, 16-bit serial link that feeds a stereo converter. One bit clock is shared by both channels. Each channel has its own data line and its own latch line. On every rising edge of the bit clock, each channel shifts the current level of its data line into a free-running shift register. A falling edge on a channel's latch line copies the 16 most recently shifted bits into that channel's sample register and raises a one-cycle update pulse. The number of bits shifted before the latch does not matter.

All five link lines are asynchronous to the system clock. Each line passes through a two-flop synchronizer, and edges are detected on the synchronized copies. The system clock must run at least four times faster than the bit clock. Samples are two's complement and sent most significant bit first, and they reset to zero, which is mid-scale. A board may tie the two latch lines together, the two data lines together, or both. The block behaves correctly in each of these wirings.

Top module: `stereo_serial_rx`

## Requirements
- R1: After reset both sample outputs read 0x0000 and both update pulses are low.
- R2: A data bit is taken only on a rising bit-clock edge. A falling bit-clock edge, or a data line toggling while the bit clock holds its level, leaves the shift contents unchanged.
- R3: A falling edge on a channel's latch line loads that channel's sample output with its last 16 bits. The earliest of those bits lands in bit 15 (MSB first) and the latest in bit 0.
- R4: When more than 16 bits are shifted before a latch, the leading surplus bits are discarded and only the final 16 appear in the sample.
- R5: A latch on one channel leaves the other channel's sample output and update pulse untouched.
- R6: When both latch lines fall together, both samples load and both update pulses rise in the same system cycle.
- R7: When both data lines carry the same stream, both channels hold and latch the same word.
- R8: Each update pulse is high for exactly one system cycle, in the cycle its sample output takes the new value. A sample output never changes without its pulse.
- R9: The sample and its pulse take effect on the third rising system-clock edge after the latch line falls.
- R10: A rising edge on a latch line neither loads a sample nor raises a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Shared serial bit clock (asynchronous) |
| sdata_l_i | input | 1 | Left serial data line |
| sdata_r_i | input | 1 | Right serial data line |
| strobe_l_i | input | 1 | Left latch line, acts on its falling edge |
| strobe_r_i | input | 1 | Right latch line, acts on its falling edge |
| sample_l_o | output | 16 | Left two's complement sample |
| sample_r_o | output | 16 | Right two's complement sample |
| update_l_o | output | 1 | One-cycle pulse when the left sample loads |
| update_r_o | output | 1 | One-cycle pulse when the right sample loads |

## Verification
The hardest case to reach is a latch where the shift register has moved well past a word boundary. Such a latch must capture only the tail of a longer burst and must not be disturbed by data wiggles that arrive without clock edges. The stimulus reaches it by sending a 20-bit burst and then latching both channels from one shared edge. It then toggles the data lines many times with the bit clock frozen and latches again. It also steps a latch edge through the synchronizer one system cycle at a time, to pin the exact load cycle against the behavioural reference model.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int CHANS = 2;
  localparam int LINE_BCLK = 0;
  localparam int LINE_DATA0 = 1;
  localparam int LINE_STROBE0 = LINE_DATA0 + CHANS;
  localparam int LINES = LINE_STROBE0 + CHANS;

  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;
endpackage

// File: rtl/srx_line_sync.sv
module srx_line_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lines_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  localparam int DEPTH = STAGES + 1;

  logic [W-1:0] chain_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) chain_q[i] <= '0;
    end else begin
      chain_q[0] <= lines_i;
      for (int i = 1; i < DEPTH; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall_o  = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/srx_chan_shifter.sv
module srx_chan_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_i,
  input  logic              load_en,
  output logic [WORD_W-1:0] word_o,
  output logic              load_o
);
  logic [WORD_W-1:0] shift_q;
  logic [WORD_W-1:0] word_q;
  logic              load_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
    end else if (shift_en) begin
      shift_q <= {shift_q[WORD_W-2:0], bit_i};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= load_en;
      if (load_en) word_q <= shift_q;
    end
  end

  assign word_o = word_q;
  assign load_o = load_q;
endmodule

// File: rtl/stereo_serial_rx.sv
module stereo_serial_rx #(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bclk_i,
  input  logic              sdata_l_i,
  input  logic              sdata_r_i,
  input  logic              strobe_l_i,
  input  logic              strobe_r_i,
  output logic [WORD_W-1:0] sample_l_o,
  output logic [WORD_W-1:0] sample_r_o,
  output logic              update_l_o,
  output logic              update_r_o
);
  import srx_pkg::*;

  logic [LINES-1:0] raw_lines;
  logic [LINES-1:0] lvl;
  logic [LINES-1:0] rise;
  logic [LINES-1:0] fall;

  logic [WORD_W-1:0] words [CHANS];
  logic [CHANS-1:0]  loads;

  assign raw_lines[LINE_BCLK]                  = bclk_i;
  assign raw_lines[LINE_DATA0 + int'(CH_LEFT)]   = sdata_l_i;
  assign raw_lines[LINE_DATA0 + int'(CH_RIGHT)]  = sdata_r_i;
  assign raw_lines[LINE_STROBE0 + int'(CH_LEFT)]  = strobe_l_i;
  assign raw_lines[LINE_STROBE0 + int'(CH_RIGHT)] = strobe_r_i;

  srx_line_sync #(
    .W      (LINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .lines_i (raw_lines),
    .level_o (lvl),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  for (genvar ch = 0; ch < CHANS; ch++) begin : g_chan
    srx_chan_shifter #(
      .WORD_W (WORD_W)
    ) u_shift (
      .clk      (clk),
      .rst      (rst),
      .shift_en (rise[LINE_BCLK]),
      .bit_i    (lvl[LINE_DATA0 + ch]),
      .load_en  (fall[LINE_STROBE0 + ch]),
      .word_o   (words[ch]),
      .load_o   (loads[ch])
    );
  end

  assign sample_l_o = words[int'(CH_LEFT)];
  assign sample_r_o = words[int'(CH_RIGHT)];
  assign update_l_o = loads[int'(CH_LEFT)];
  assign update_r_o = loads[int'(CH_RIGHT)];
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              strobe_l_i,
  input logic              strobe_r_i,
  input logic [WORD_W-1:0] sample_l_o,
  input logic [WORD_W-1:0] sample_r_o,
  input logic              update_l_o,
  input logic              update_r_o
);
  // R1: leaving reset, outputs are at mid-scale and quiet
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (sample_l_o == '0 && sample_r_o == '0 && !update_l_o && !update_r_o));

  // R8: pulses last one cycle
  a_r8_left_one_cycle: assert property (@(posedge clk) disable iff (rst)
    update_l_o |=> !update_l_o);
  a_r8_right_one_cycle: assert property (@(posedge clk) disable iff (rst)
    update_r_o |=> !update_r_o);

  // R8 / R5: a sample never moves without its own pulse
  a_r8_left_change_pulsed: assert property (@(posedge clk) disable iff (rst)
    !$stable(sample_l_o) |-> update_l_o);
  a_r8_right_change_pulsed: assert property (@(posedge clk) disable iff (rst)
    !$stable(sample_r_o) |-> update_r_o);

  // R9 / R10: a pulse traces back to a falling latch line three edges earlier
  a_r9_left_from_fall: assert property (@(posedge clk) disable iff (rst)
    update_l_o |-> ($past(strobe_l_i, 4) && !$past(strobe_l_i, 3)));
  a_r9_right_from_fall: assert property (@(posedge clk) disable iff (rst)
    update_r_o |-> ($past(strobe_r_i, 4) && !$past(strobe_r_i, 3)));
endmodule

bind stereo_serial_rx srx_checker #(.WORD_W(WORD_W)) u_srx_checker (
  .clk        (clk),
  .rst        (rst),
  .strobe_l_i (strobe_l_i),
  .strobe_r_i (strobe_r_i),
  .sample_l_o (sample_l_o),
  .sample_r_o (sample_r_o),
  .update_l_o (update_l_o),
  .update_r_o (update_r_o)
);

// File: tb/tb_stereo_serial_rx.sv
module tb_stereo_serial_rx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bclk = 1'b0;
  logic        dl = 1'b0;
  logic        dr = 1'b0;
  logic        sl = 1'b1;
  logic        sr = 1'b1;
  logic [15:0] q_l, q_r;
  logic        up_l, up_r;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pulses_l = 0, pulses_r = 0;
  int last_l = -1, last_r = -1;

  always #4 clk = ~clk;

  stereo_serial_rx dut (
    .clk (clk), .rst (rst), .bclk_i (bclk),
    .sdata_l_i (dl), .sdata_r_i (dr),
    .strobe_l_i (sl), .strobe_r_i (sr),
    .sample_l_o (q_l), .sample_r_o (q_r),
    .update_l_o (up_l), .update_r_o (up_r)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference model: history of driven lines, evaluated per clock
  logic [4:0]  hist[$];
  logic [15:0] m_sh_l, m_sh_r, m_q_l, m_q_r;
  logic        m_up_l, m_up_r;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      hist = {5'd0, 5'd0, 5'd0};
      m_sh_l = 0; m_sh_r = 0; m_q_l = 0; m_q_r = 0;
      m_up_l = 0; m_up_r = 0;
    end else begin
      logic [4:0] older, newer;
      hist.push_back({sr, sl, dr, dl, bclk});
      older = hist[hist.size()-4];
      newer = hist[hist.size()-3];
      m_up_l = older[3] && !newer[3];
      m_up_r = older[4] && !newer[4];
      if (m_up_l) m_q_l = m_sh_l;
      if (m_up_r) m_q_r = m_sh_r;
      if (newer[0] && !older[0]) begin
        m_sh_l = {m_sh_l[14:0], newer[1]};
        m_sh_r = {m_sh_r[14:0], newer[2]};
      end
      while (hist.size() > 4) void'(hist.pop_front());
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check("R3/R5 model left sample", q_l, m_q_l);
      check("R3/R5 model right sample", q_r, m_q_r);
      check("R8/R9 model left pulse", up_l, m_up_l);
      check("R8/R9 model right pulse", up_r, m_up_r);
      if (up_l) begin pulses_l++; last_l = cyc; end
      if (up_r) begin pulses_r++; last_r = cyc; end
    end
  end

  task automatic send_bit(input logic bl, input logic br);
    @(negedge clk);
    dl = bl; dr = br; bclk = 1'b0;
    repeat (3) @(negedge clk);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_word(input logic [15:0] wl, input logic [15:0] wr);
    for (int i = 15; i >= 0; i--) send_bit(wl[i], wr[i]);
  endtask

  task automatic latch(input logic do_l, input logic do_r);
    @(negedge clk);
    if (do_l) sl = 1'b0;
    if (do_r) sr = 1'b0;
    repeat (4) @(negedge clk);
    sl = 1'b1; sr = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int pl, pr;
    repeat (4) @(negedge clk);
    // R1: reset values
    check("R1 left sample at reset", q_l, 16'h0000);
    check("R1 right sample at reset", q_r, 16'h0000);
    check("R1 pulses at reset", {up_l, up_r}, 2'b00);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 left sample after reset", q_l, 16'h0000);

    // R3 / R5: independent words, left latch only
    send_word(16'h8001, 16'h7FFE);
    latch(1'b1, 1'b0);
    check("R3 left word MSB first", q_l, 16'h8001);
    check("R5 right untouched by left latch", q_r, 16'h0000);
    latch(1'b0, 1'b1);
    check("R3 right word", q_r, 16'h7FFE);
    check("R5 left untouched by right latch", q_l, 16'h8001);

    // R4 / R6: 20-bit burst, shared latch edge
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
    send_word(16'h1234, 16'hFEDC);
    latch(1'b1, 1'b1);
    check("R4 left keeps last 16 bits", q_l, 16'h1234);
    check("R4 right keeps last 16 bits", q_r, 16'hFEDC);
    check("R6 shared latch same cycle", last_l, last_r);

    // R7: shared data stream
    send_word(16'hA5C3, 16'hA5C3);
    latch(1'b1, 1'b1);
    check("R7 shared data left", q_l, 16'hA5C3);
    check("R7 shared data right", q_r, 16'hA5C3);

    // R2: data wiggles with bit clock frozen high, then latch again
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      dl = ~dl; dr = ~dr;
    end
    latch(1'b1, 1'b1);
    check("R2 no shift without rising bit clock (L)", q_l, 16'hA5C3);
    check("R2 no shift without rising bit clock (R)", q_r, 16'hA5C3);

    // R9 / R8: exact load cycle and pulse width on the left channel
    send_word(16'h0F0F, 16'h3333);
    @(negedge clk);
    sl = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R9 no pulse before third edge", up_l, 1'b0);
    check("R9 sample not yet loaded", q_l, 16'hA5C3);
    @(posedge clk); @(negedge clk);
    check("R9 pulse on third edge", up_l, 1'b1);
    check("R9 sample loaded on third edge", q_l, 16'h0F0F);
    @(posedge clk); @(negedge clk);
    check("R8 pulse one cycle wide", up_l, 1'b0);

    // R10: rising latch edge does nothing
    pl = pulses_l; pr = pulses_r;
    repeat (3) @(negedge clk);
    sl = 1'b1;
    repeat (8) @(negedge clk);
    check("R10 no pulse on rising latch", pulses_l, pl);
    check("R10 sample unchanged on rising latch", q_l, 16'h0F0F);
    check("R5 right unchanged by left activity", pulses_r, pr);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule